// File: doc/BRIEF.md
# Keyed Index/Data Configuration Port

This block is a byte-wide configuration port for a host that reaches a set of internal registers through two addresses. Offset 0 is the index port and offset 1 is the data port. The host first writes a register index to the index port. It then reads or writes that register through the data port.

The register space is closed after reset. It opens only when a fixed key byte arrives on the index port twice in a row. A different byte on the index port closes it again. While closed, data reads return all ones and data writes change nothing.

Indices below 0x30 are global and visible in every bank. These are:
- the bank select register;
- the identification bytes;
- three pin-function bytes that drive a top-level output.

Indices at 0x30 and above belong to the logical device picked by the bank select. The block holds the enable bit and the base address of one attached device. Every other per-device index is forwarded to that device over an index/strobe/data port.

Top module: `keyed_cfg_port`

## Requirements
- R1: After reset the port is closed, bank select is 0x00, the device enable bit is 0, the device base address is 0x0000, every pin-function byte is 0x00 and rdata_o is 0x00.
- R2: The port opens only after two consecutive index-port writes of 0x87. While closed, any read returns 0xFF. A read's result appears on rdata_o after the clock edge that samples rd_i and holds until the next read.
- R3: When 0x87 is followed by any other index-port byte, the port stays closed. Opening it afterwards again needs two consecutive 0x87 writes.
- R4: An index-port write of 0xAA closes an open port. Data-port writes made while closed change no register and raise no device strobe.
- R5: Indices 0x20/0x21 read the device ID high/low byte, 0x22 reads the revision byte, and 0x23/0x24 read the vendor ID high/low byte. All of them read the same under every bank select.
- R6: Index 0x07 is a read/write bank-select byte. While open, a read of the index port returns the latched index, and any index-port byte other than 0xAA is latched as the index.
- R7: Indices 0x29, 0x2A and 0x2B are read/write bytes that drive mux_o bits 7:0, 15:8 and 23:16 respectively.
- R8: When bank select equals the attached device number (0x07), index 0x30 bit 0 is the device enable, with bits 7:1 reading 0. Index 0x60 is the base address high byte and 0x61 the low byte. These appear on dev_en_o and dev_base_o.
- R9: When bank select matches, any other index of 0x30 or above is forwarded. A data write raises dev_wr_o for one cycle with dev_idx_o set to the index and dev_wdata_o set to the byte. A data read raises dev_rd_o and returns dev_rdata_i.
- R10: When bank select does not match, reads of indices 0x30 and above return 0xFF. Writes to them raise no strobe and leave dev_en_o and dev_base_o unchanged.
- R11: A read and a write in the same cycle: the read returns the state from before that write, including the previous index and the previous open state.
- R12: Global indices below 0x30 that hold no register read 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_i | input | 1 | Host write strobe |
| wr_addr_i | input | 1 | Write target: 0 index port, 1 data port |
| wdata_i | input | 8 | Host write byte |
| rd_i | input | 1 | Host read strobe |
| rd_addr_i | input | 1 | Read target: 0 index port, 1 data port |
| rdata_o | output | 8 | Registered read byte |
| mux_o | output | 24 | Pin-function bytes |
| dev_en_o | output | 1 | Attached device enable |
| dev_base_o | output | 16 | Attached device base address |
| dev_idx_o | output | 8 | Forwarded register index |
| dev_wdata_o | output | 8 | Forwarded write byte |
| dev_wr_o | output | 1 | Forwarded write strobe |
| dev_rd_o | output | 1 | Forwarded read strobe |
| dev_rdata_i | input | 8 | Read byte from the attached device |

## Verification
Reads and writes have separate strobes and addresses, so a data-port read can share a cycle with an index-port write. That write may change the index, or it may be the closing key. The bench drives both strobes together in one cycle: first with a new index, then with the 0xAA close byte. It expects the read to return the register picked by the old index, not 0xFF. A second read then confirms the write took effect. Forwarded strobes are checked in the same cycle they are driven, under both a matching and a non-matching bank select.

// File: rtl/keyed_cfg_port_pkg.sv
package keyed_cfg_port_pkg;
  localparam int BYTE_W = 8;
  localparam logic [BYTE_W-1:0] KEY_OPEN   = 8'h87;
  localparam logic [BYTE_W-1:0] KEY_CLOSE  = 8'hAA;
  localparam logic [BYTE_W-1:0] RD_IDLE    = 8'hFF;
  localparam logic [BYTE_W-1:0] IX_BANK    = 8'h07;
  localparam logic [BYTE_W-1:0] IX_DID_H   = 8'h20;
  localparam logic [BYTE_W-1:0] IX_DID_L   = 8'h21;
  localparam logic [BYTE_W-1:0] IX_REV     = 8'h22;
  localparam logic [BYTE_W-1:0] IX_VID_H   = 8'h23;
  localparam logic [BYTE_W-1:0] IX_VID_L   = 8'h24;
  localparam logic [BYTE_W-1:0] IX_MUX0    = 8'h29;
  localparam logic [BYTE_W-1:0] IX_UPPER   = 8'h30;
  localparam logic [BYTE_W-1:0] IX_EN      = 8'h30;
  localparam logic [BYTE_W-1:0] IX_BASE_H  = 8'h60;
  localparam logic [BYTE_W-1:0] IX_BASE_L  = 8'h61;

  typedef enum logic [1:0] {KS_LOCKED, KS_HALF, KS_OPEN} key_state_e;
endpackage

// File: rtl/keyed_cfg_key_fsm.sv
module keyed_cfg_key_fsm
  import keyed_cfg_port_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              idx_wr_i,
  input  logic [BYTE_W-1:0] byte_i,
  output logic              open_o,
  output logic [BYTE_W-1:0] idx_o
);
  key_state_e state_q;
  logic [BYTE_W-1:0] idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= KS_LOCKED;
      idx_q   <= '0;
    end else if (idx_wr_i) begin
      unique case (state_q)
        KS_LOCKED: if (byte_i == KEY_OPEN) state_q <= KS_HALF;
        KS_HALF:   state_q <= (byte_i == KEY_OPEN) ? KS_OPEN : KS_LOCKED;
        KS_OPEN: begin
          if (byte_i == KEY_CLOSE) state_q <= KS_LOCKED;
          else                     idx_q   <= byte_i;
        end
        default:   state_q <= KS_LOCKED;
      endcase
    end
  end

  assign open_o = (state_q == KS_OPEN);
  assign idx_o  = idx_q;

  assert_unlock_key_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(open_o) |-> $past(idx_wr_i && byte_i == KEY_OPEN));
  assert_key_break_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!open_o && idx_wr_i && byte_i != KEY_OPEN) |=> !open_o);
  assert_close_key_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (open_o && idx_wr_i && byte_i == KEY_CLOSE) |=> !open_o);
endmodule

// File: rtl/keyed_cfg_glob_regs.sv
module keyed_cfg_glob_regs
  import keyed_cfg_port_pkg::*;
#(
  parameter logic [15:0] DEV_ID  = 16'h1234,
  parameter logic [7:0]  REV_ID  = 8'h05,
  parameter logic [15:0] VEND_ID = 16'h4A5B,
  parameter int          MUX_N   = 3,
  localparam int         MUX_W   = MUX_N * BYTE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [BYTE_W-1:0] idx_i,
  input  logic [BYTE_W-1:0] wdata_i,
  output logic [BYTE_W-1:0] bank_o,
  output logic [MUX_W-1:0]  mux_o,
  output logic [BYTE_W-1:0] rdata_o
);
  logic [BYTE_W-1:0] bank_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       bank_q <= '0;
    else if (wr_i && idx_i == IX_BANK) bank_q <= wdata_i;
  end
  assign bank_o = bank_q;

  for (genvar k = 0; k < MUX_N; k++) begin : g_mux
    logic [BYTE_W-1:0] r_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                            r_q <= '0;
      else if (wr_i && idx_i == IX_MUX0 + BYTE_W'(k)) r_q <= wdata_i;
    end
    assign mux_o[k*BYTE_W +: BYTE_W] = r_q;
  end

  always_comb begin
    rdata_o = '0;
    unique case (idx_i)
      IX_BANK:  rdata_o = bank_q;
      IX_DID_H: rdata_o = DEV_ID[15:8];
      IX_DID_L: rdata_o = DEV_ID[7:0];
      IX_REV:   rdata_o = REV_ID;
      IX_VID_H: rdata_o = VEND_ID[15:8];
      IX_VID_L: rdata_o = VEND_ID[7:0];
      default:  ;
    endcase
    for (int k = 0; k < MUX_N; k++)
      if (idx_i == IX_MUX0 + BYTE_W'(k)) rdata_o = mux_o[k*BYTE_W +: BYTE_W];
  end

  assert_bank_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> $stable(bank_o));
endmodule

// File: rtl/keyed_cfg_dev_bank.sv
module keyed_cfg_dev_bank
  import keyed_cfg_port_pkg::*;
#(
  parameter logic [7:0] DEV_LDN = 8'h07
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [BYTE_W-1:0] idx_i,
  input  logic [BYTE_W-1:0] wdata_i,
  input  logic [BYTE_W-1:0] bank_i,
  input  logic [BYTE_W-1:0] dev_rdata_i,
  output logic              en_o,
  output logic [15:0]       base_o,
  output logic [BYTE_W-1:0] dev_idx_o,
  output logic [BYTE_W-1:0] dev_wdata_o,
  output logic              dev_wr_o,
  output logic              dev_rd_o,
  output logic [BYTE_W-1:0] rdata_o
);
  logic sel, local_hit, fwd;
  logic en_q;
  logic [15:0] base_q;

  assign sel       = (bank_i == DEV_LDN);
  assign local_hit = (idx_i == IX_EN) || (idx_i == IX_BASE_H) || (idx_i == IX_BASE_L);
  assign fwd       = sel && (idx_i >= IX_UPPER) && !local_hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= 1'b0;
      base_q <= '0;
    end else if (wr_i && sel) begin
      if (idx_i == IX_EN)     en_q         <= wdata_i[0];
      if (idx_i == IX_BASE_H) base_q[15:8] <= wdata_i;
      if (idx_i == IX_BASE_L) base_q[7:0]  <= wdata_i;
    end
  end

  assign en_o        = en_q;
  assign base_o      = base_q;
  assign dev_idx_o   = idx_i;
  assign dev_wdata_o = wdata_i;
  assign dev_wr_o    = wr_i && fwd;
  assign dev_rd_o    = rd_i && fwd;

  always_comb begin
    if (!sel)                    rdata_o = RD_IDLE;
    else if (idx_i == IX_EN)     rdata_o = {{(BYTE_W-1){1'b0}}, en_q};
    else if (idx_i == IX_BASE_H) rdata_o = base_q[15:8];
    else if (idx_i == IX_BASE_L) rdata_o = base_q[7:0];
    else                         rdata_o = dev_rdata_i;
  end

  assert_foreign_bank_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bank_i != DEV_LDN) |=> ($stable(en_o) && $stable(base_o)));
endmodule

// File: rtl/keyed_cfg_port.sv
module keyed_cfg_port
  import keyed_cfg_port_pkg::*;
#(
  parameter logic [15:0] DEV_ID  = 16'h1234,
  parameter logic [7:0]  REV_ID  = 8'h05,
  parameter logic [15:0] VEND_ID = 16'h4A5B,
  parameter logic [7:0]  DEV_LDN = 8'h07,
  parameter int          MUX_N   = 3,
  localparam int         MUX_W   = MUX_N * BYTE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic              wr_addr_i,
  input  logic [BYTE_W-1:0] wdata_i,
  input  logic              rd_i,
  input  logic              rd_addr_i,
  output logic [BYTE_W-1:0] rdata_o,
  output logic [MUX_W-1:0]  mux_o,
  output logic              dev_en_o,
  output logic [15:0]       dev_base_o,
  output logic [BYTE_W-1:0] dev_idx_o,
  output logic [BYTE_W-1:0] dev_wdata_o,
  output logic              dev_wr_o,
  output logic              dev_rd_o,
  input  logic [BYTE_W-1:0] dev_rdata_i
);
  logic open, idx_wr, dat_wr, dat_rd;
  logic [BYTE_W-1:0] idx, bank, glob_rd, dev_rd_val, rd_next, rdata_q;

  assign idx_wr = wr_i && !wr_addr_i;
  assign dat_wr = wr_i &&  wr_addr_i && open;
  assign dat_rd = rd_i &&  rd_addr_i && open;

  keyed_cfg_key_fsm u_key (
    .clk_i, .rst_ni, .idx_wr_i(idx_wr), .byte_i(wdata_i),
    .open_o(open), .idx_o(idx)
  );

  keyed_cfg_glob_regs #(
    .DEV_ID(DEV_ID), .REV_ID(REV_ID), .VEND_ID(VEND_ID), .MUX_N(MUX_N)
  ) u_glob (
    .clk_i, .rst_ni, .wr_i(dat_wr && idx < IX_UPPER), .idx_i(idx),
    .wdata_i, .bank_o(bank), .mux_o, .rdata_o(glob_rd)
  );

  keyed_cfg_dev_bank #(.DEV_LDN(DEV_LDN)) u_dev (
    .clk_i, .rst_ni,
    .wr_i(dat_wr && idx >= IX_UPPER), .rd_i(dat_rd && idx >= IX_UPPER),
    .idx_i(idx), .wdata_i, .bank_i(bank), .dev_rdata_i,
    .en_o(dev_en_o), .base_o(dev_base_o), .dev_idx_o, .dev_wdata_o,
    .dev_wr_o, .dev_rd_o, .rdata_o(dev_rd_val)
  );

  // read sees pre-edge state, so a same-cycle write never leaks in
  always_comb begin
    if (!open)                rd_next = RD_IDLE;
    else if (!rd_addr_i)      rd_next = idx;
    else if (idx < IX_UPPER)  rd_next = glob_rd;
    else                      rd_next = dev_rd_val;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_q <= '0;
    else if (rd_i) rdata_q <= rd_next;
  end
  assign rdata_o = rdata_q;

  assert_locked_read_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !open) |=> (rdata_o == RD_IDLE));
  assert_no_strobe_locked_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !open |-> (!dev_wr_o && !dev_rd_o));
  assert_read_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> $stable(rdata_o));
endmodule

// File: tb/keyed_cfg_port_test.sv
`timescale 1ns/100ps
module keyed_cfg_port_test;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic wr_i = 1'b0, wr_addr_i = 1'b0, rd_i = 1'b0, rd_addr_i = 1'b0;
  logic [7:0] wdata_i = '0;
  logic [7:0] rdata_o, dev_idx_o, dev_wdata_o, dev_rdata_i;
  logic [23:0] mux_o;
  logic dev_en_o, dev_wr_o, dev_rd_o;
  logic [15:0] dev_base_o;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  assign dev_rdata_i = dev_idx_o ^ 8'h5A;

  keyed_cfg_port uut (
    .clk_i(clk), .rst_ni, .wr_i, .wr_addr_i, .wdata_i, .rd_i, .rd_addr_i,
    .rdata_o, .mux_o, .dev_en_o, .dev_base_o, .dev_idx_o, .dev_wdata_o,
    .dev_wr_o, .dev_rd_o, .dev_rdata_i
  );

  // {rd, port, byte, expected, req}
  localparam int NV = 43;
  localparam logic [21:0] VEC [NV] = '{
    {1'b0,1'b0,8'h87,8'h00,4'd2},  // R2 key 1
    {1'b0,1'b0,8'h87,8'h00,4'd2},  // R2 key 2
    {1'b0,1'b0,8'h20,8'h00,4'd5},
    {1'b1,1'b1,8'h00,8'h12,4'd5},  // R5 device id high
    {1'b0,1'b0,8'h21,8'h00,4'd5},
    {1'b1,1'b1,8'h00,8'h34,4'd5},
    {1'b0,1'b0,8'h22,8'h00,4'd5},
    {1'b1,1'b1,8'h00,8'h05,4'd5},  // R5 revision
    {1'b0,1'b0,8'h23,8'h00,4'd5},
    {1'b1,1'b1,8'h00,8'h4A,4'd5},
    {1'b0,1'b0,8'h24,8'h00,4'd5},
    {1'b1,1'b1,8'h00,8'h5B,4'd5},  // R5 vendor id low
    {1'b0,1'b0,8'h07,8'h00,4'd6},
    {1'b0,1'b1,8'h07,8'h00,4'd6},
    {1'b1,1'b1,8'h00,8'h07,4'd6},  // R6 bank select readback
    {1'b1,1'b0,8'h00,8'h07,4'd6},  // R6 index port readback
    {1'b0,1'b0,8'h29,8'h00,4'd7},
    {1'b0,1'b1,8'hA5,8'h00,4'd7},
    {1'b1,1'b1,8'h00,8'hA5,4'd7},  // R7 first mux byte
    {1'b0,1'b0,8'h2B,8'h00,4'd7},
    {1'b0,1'b1,8'h3C,8'h00,4'd7},
    {1'b1,1'b1,8'h00,8'h3C,4'd7},  // R7 third mux byte
    {1'b0,1'b0,8'h30,8'h00,4'd8},
    {1'b0,1'b1,8'hFF,8'h00,4'd8},
    {1'b1,1'b1,8'h00,8'h01,4'd8},  // R8 only bit 0 kept
    {1'b0,1'b0,8'h60,8'h00,4'd8},
    {1'b0,1'b1,8'h0A,8'h00,4'd8},
    {1'b1,1'b1,8'h00,8'h0A,4'd8},
    {1'b0,1'b0,8'h61,8'h00,4'd8},
    {1'b0,1'b1,8'h2E,8'h00,4'd8},
    {1'b1,1'b1,8'h00,8'h2E,4'd8},  // R8 base low
    {1'b0,1'b0,8'h25,8'h00,4'd12},
    {1'b1,1'b1,8'h00,8'h00,4'd12}, // R12 empty global index
    {1'b0,1'b0,8'h07,8'h00,4'd10},
    {1'b0,1'b1,8'h03,8'h00,4'd10},
    {1'b0,1'b0,8'h30,8'h00,4'd10},
    {1'b1,1'b1,8'h00,8'hFF,4'd10}, // R10 foreign bank reads FF
    {1'b0,1'b0,8'h20,8'h00,4'd5},
    {1'b1,1'b1,8'h00,8'h12,4'd5},  // R5 id in any bank
    {1'b0,1'b0,8'h07,8'h00,4'd6},
    {1'b0,1'b1,8'h07,8'h00,4'd6},
    {1'b0,1'b0,8'hAA,8'h00,4'd4},
    {1'b1,1'b1,8'h00,8'hFF,4'd4}   // R4 closed again
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic port, input logic [7:0] b);
    @(negedge clk);
    wr_i = 1'b1; wr_addr_i = port; wdata_i = b;
    @(negedge clk);
    wr_i = 1'b0;
  endtask

  task automatic rd(input logic port, output logic [7:0] v);
    @(negedge clk);
    rd_i = 1'b1; rd_addr_i = port;
    @(negedge clk);
    rd_i = 1'b0;
    v = rdata_o;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    repeat (4) @(negedge clk);
    // R1 reset state
    check("R1 rdata", rdata_o, 8'h00);
    check("R1 en", dev_en_o, 1'b0);
    check("R1 base", dev_base_o, 16'h0000);
    check("R1 mux", mux_o, 24'h0);
    rst_ni = 1'b1;
    rd(1'b1, v); check("R2 locked read", v, 8'hFF);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][21]) begin
        rd(VEC[i][20], v);
        checks++;
        if (v !== VEC[i][11:4]) begin
          fails++;
          $display("FAIL vec %0d R%0d actual=%0h expected=%0h", i, VEC[i][3:0], v, VEC[i][11:4]);
        end
      end else begin
        wr(VEC[i][20], VEC[i][19:12]);
      end
    end
    check("R7 mux_o", mux_o, 24'h3C00A5);
    check("R8 dev_en_o", dev_en_o, 1'b1);
    check("R8 dev_base_o", dev_base_o, 16'h0A2E);

    // R3 broken key sequence
    wr(1'b0, 8'h87); wr(1'b0, 8'h11); wr(1'b0, 8'h87);
    rd(1'b1, v); check("R3 still closed", v, 8'hFF);
    wr(1'b0, 8'h87); wr(1'b0, 8'h07);
    rd(1'b1, v); check("R3 opens after fresh pair", v, 8'h07);

    // R4 writes ignored while closed
    wr(1'b0, 8'hAA);
    @(negedge clk); wr_i = 1'b1; wr_addr_i = 1'b1; wdata_i = 8'h55;
    #1 check("R4 no strobe closed", dev_wr_o, 1'b0);
    @(negedge clk); wr_i = 1'b0;
    wr(1'b0, 8'h87); wr(1'b0, 8'h87); wr(1'b0, 8'h07);
    rd(1'b1, v); check("R4 bank unchanged", v, 8'h07);

    // R9 forwarding
    wr(1'b0, 8'h45);
    @(negedge clk); wr_i = 1'b1; wr_addr_i = 1'b1; wdata_i = 8'h9C;
    #1 check("R9 dev_wr_o", dev_wr_o, 1'b1);
    check("R9 dev_idx_o", dev_idx_o, 8'h45);
    check("R9 dev_wdata_o", dev_wdata_o, 8'h9C);
    @(negedge clk); wr_i = 1'b0;
    #1 check("R9 write strobe one cycle", dev_wr_o, 1'b0);
    @(negedge clk); rd_i = 1'b1; rd_addr_i = 1'b1;
    #1 check("R9 dev_rd_o", dev_rd_o, 1'b1);
    @(negedge clk); rd_i = 1'b0;
    check("R9 forwarded read", rdata_o, 8'h1F);

    // R10 foreign bank
    wr(1'b0, 8'h07); wr(1'b1, 8'h03);
    wr(1'b0, 8'h45);
    @(negedge clk); wr_i = 1'b1; wr_addr_i = 1'b1; wdata_i = 8'h77;
    #1 check("R10 no strobe", dev_wr_o, 1'b0);
    @(negedge clk); wr_i = 1'b0;
    wr(1'b0, 8'h30); wr(1'b1, 8'h00);
    wr(1'b0, 8'h60); wr(1'b1, 8'h00);
    check("R10 en kept", dev_en_o, 1'b1);
    check("R10 base kept", dev_base_o, 16'h0A2E);
    wr(1'b0, 8'h07); wr(1'b1, 8'h07);

    // R11 same-cycle read and write
    wr(1'b0, 8'h30);
    @(negedge clk); wr_i = 1'b1; wr_addr_i = 1'b0; wdata_i = 8'h22;
    rd_i = 1'b1; rd_addr_i = 1'b1;
    @(negedge clk); wr_i = 1'b0; rd_i = 1'b0;
    check("R11 read uses old index", rdata_o, 8'h01);
    rd(1'b1, v); check("R11 new index took effect", v, 8'h05);
    @(negedge clk); wr_i = 1'b1; wr_addr_i = 1'b0; wdata_i = 8'hAA;
    rd_i = 1'b1; rd_addr_i = 1'b1;
    @(negedge clk); wr_i = 1'b0; rd_i = 1'b0;
    check("R11 read before close", rdata_o, 8'h05);
    rd(1'b1, v); check("R11 closed after", v, 8'hFF);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule